// File: doc/BRIEF.md
# Per-Period Delay Offset Pipeline

This block sits between a pattern source and a set of per-channel timing generators in a test system. Once per tester period, an early period-start strobe arrives on the master clock together with an 8-bit offset byte. The block registers that byte, along with each channel's programmed edge delay. It then adds the offset to all four channel delays, so every edge in that period moves by the same amount. Each period may carry a different offset, and one period's value never leaks into another.

Each sum is 9 bits wide. The low 8 bits go out as the edge delay, and the top bit goes out as a carry flag that marks an edge pushed past one period. Sums move through three more period-advanced stages, which step only on strobes, and then through four master-clock stages. The output valid flag pulses once for each period that emerges.

A second path carries the offset toward the fail-result side. Its latency is eight strobes plus a selectable alignment of 0 to 7 further strobes. That alignment is picked as a tap of a shift register.

Top module: `per_period_offset_pipe`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every stage, so after it out_vld, ret_vld, out_dly and out_cry are all zero.
- R2: ofs_in and dly_in are sampled only at edges where t0_en is high; values presented on other cycles have no effect on any output.
- R3: For channel c, out_dly[8c+7:8c] equals the low 8 bits of ofs + dly[c], and out_cry[c] equals bit 8 of that 9-bit sum (set when the sum is 256 or more).
- R4: Each period uses its own offset: item n on the outputs carries the offset and delays sampled at the n-th strobe after reset, in strobe order.
- R5: Item n appears with out_vld high in the cycle that follows the fourth clock edge after the edge of strobe n+3 (four period stages, then four clock stages).
- R6: out_vld is high for exactly one cycle per emerging period, so the number of output items equals the number of strobes minus three. Back-to-back strobes on consecutive cycles are supported.
- R7: After the edge of strobe k, ret_ofs equals the offset of strobe k-7-a, where a is align_sel (0 to 7). ret_ofs only changes on the cycle after a strobe.
- R8: ret_vld stays low until strobe 7+a (counting from 0 after reset) has been taken, and is high from then on.
- R9: The four channels are summed independently: each channel's result depends only on its own dly_in byte and the shared offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| t0_en | input | 1 | Early period-start strobe; acts as the capture enable |
| ofs_in | input | 8 | Per-period delay offset |
| dly_in | input | 32 | Programmed edge delays, channel c in bits 8c+7:8c |
| align_sel | input | 3 | Extra return-path alignment, in strobes |
| out_vld | output | 1 | Pulses once per emerging period |
| out_dly | output | 32 | Summed edge delays, low 8 bits per channel |
| out_cry | output | 4 | Per-channel carry past one period |
| ret_vld | output | 1 | Return-path offset valid |
| ret_ofs | output | 8 | Offset delayed by 8 plus align_sel strobes |

## Verification
A stage that advances on the wrong enable shows up as out_vld firing off its expected cycle, measured against the strobe edge three strobes later plus four clocks. It can also show up as the right data from the wrong period, and either is caught at the first item after the pipeline fills. A capture register that is not gated by the strobe picks up the junk driven between strobes, which corrupts the very next item. A wrong return tap shows up on the first strobe after the return chain fills, as a wrong ret_ofs or as ret_vld rising early or late. A bad adder or carry shows up as a mismatch on the boundary sums 255+1, 255+255 and 0+0.

// File: rtl/per_period_offset_pipe.sv
module per_period_offset_pipe #(
  parameter int NCH      = 4,
  parameter int OW       = 8,
  parameter int PSTG     = 4,
  parameter int CSTG     = 4,
  parameter int RET_BASE = 8,
  parameter int AW       = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                t0_en,
  input  logic [OW-1:0]       ofs_in,
  input  logic [NCH*OW-1:0]   dly_in,
  input  logic [AW-1:0]       align_sel,
  output logic                out_vld,
  output logic [NCH*OW-1:0]   out_dly,
  output logic [NCH-1:0]      out_cry,
  output logic                ret_vld,
  output logic [OW-1:0]       ret_ofs
);
  localparam int SW   = OW + 1;
  localparam int NSUM = PSTG - 1;
  localparam int RDEP = RET_BASE - 1 + (1 << AW);

  logic                       t0_d;
  logic [OW-1:0]              ofs_q;
  logic [NCH-1:0][OW-1:0]     dly_q;
  logic                       cap_v;
  logic [NCH-1:0][SW-1:0]     sum_w;

  logic [NSUM-1:0]            pv;
  logic [NCH-1:0][SW-1:0]     pd [NSUM];
  logic [CSTG-1:0]            cv;
  logic [NCH-1:0][SW-1:0]     cd [CSTG];
  logic [RDEP-1:0]            rv;
  logic [OW-1:0]              ro [RDEP];

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q <= '0;
      dly_q <= '0;
      cap_v <= 1'b0;
      t0_d  <= 1'b0;
    end else begin
      t0_d <= t0_en;
      if (t0_en) begin
        ofs_q <= ofs_in;
        dly_q <= dly_in;
        cap_v <= 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_add
    assign sum_w[c] = SW'(dly_q[c]) + SW'(ofs_q);
  end

  for (genvar j = 0; j < NSUM; j++) begin : g_per
    logic                   v_q;
    logic [NCH-1:0][SW-1:0] d_q;
    logic                   src_v;
    logic [NCH-1:0][SW-1:0] src_d;
    if (j == 0) begin : g_head
      assign src_v = cap_v;
      assign src_d = sum_w;
    end else begin : g_body
      assign src_v = pv[j-1];
      assign src_d = pd[j-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (t0_en) begin
        v_q <= src_v;
        d_q <= src_d;
      end
    end
    assign pv[j] = v_q;
    assign pd[j] = d_q;
  end

  for (genvar k = 0; k < CSTG; k++) begin : g_clk
    logic                   v_q;
    logic [NCH-1:0][SW-1:0] d_q;
    logic                   src_v;
    logic [NCH-1:0][SW-1:0] src_d;
    if (k == 0) begin : g_head
      assign src_v = t0_d & pv[NSUM-1];
      assign src_d = pd[NSUM-1];
    end else begin : g_body
      assign src_v = cv[k-1];
      assign src_d = cd[k-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= src_v;
        if (src_v) d_q <= src_d;
      end
    end
    assign cv[k] = v_q;
    assign cd[k] = d_q;
  end

  assign out_vld = cv[CSTG-1];
  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign out_dly[c*OW +: OW] = cd[CSTG-1][c][OW-1:0];
    assign out_cry[c]          = cd[CSTG-1][c][OW];
  end

  for (genvar r = 0; r < RDEP; r++) begin : g_ret
    logic          v_q;
    logic [OW-1:0] o_q;
    logic          src_v;
    logic [OW-1:0] src_o;
    if (r == 0) begin : g_head
      assign src_v = 1'b1;
      assign src_o = ofs_in;
    end else begin : g_body
      assign src_v = rv[r-1];
      assign src_o = ro[r-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        o_q <= '0;
      end else if (t0_en) begin
        v_q <= src_v;
        o_q <= src_o;
      end
    end
    assign rv[r] = v_q;
    assign ro[r] = o_q;
  end

  logic [$clog2(RDEP)-1:0] tap;
  assign tap     = $clog2(RDEP)'(RET_BASE - 1) + $clog2(RDEP)'(align_sel);
  assign ret_vld = rv[tap];
  assign ret_ofs = ro[tap];
endmodule

// File: rtl/po_pipe_chk.sv
module po_pipe_chk #(
  parameter int NCH  = 4,
  parameter int OW   = 8,
  parameter int CSTG = 4,
  parameter int AW   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              t0_en,
  input logic [AW-1:0]     align_sel,
  input logic              out_vld,
  input logic [NCH*OW-1:0] out_dly,
  input logic              ret_vld,
  input logic [OW-1:0]     ret_ofs
);
  logic [CSTG:0] sh;
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[CSTG-1:0], t0_en};
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_vld && !ret_vld));

  p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> $stable(out_dly));

  p_vld_after_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> sh[CSTG]);

  p_ret_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!sh[0] && $stable(align_sel)) |-> ($stable(ret_ofs) && $stable(ret_vld)));
endmodule

bind per_period_offset_pipe po_pipe_chk #(.NCH(NCH), .OW(OW), .CSTG(CSTG), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .t0_en(t0_en), .align_sel(align_sel),
  .out_vld(out_vld), .out_dly(out_dly), .ret_vld(ret_vld), .ret_ofs(ret_ofs)
);

// File: tb/tb_per_period_offset_pipe.sv
module tb_per_period_offset_pipe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        t0_en = 1'b0;
  logic [7:0]  ofs_in = '0;
  logic [31:0] dly_in = '0;
  logic [2:0]  align_sel = '0;
  logic        out_vld;
  logic [31:0] out_dly;
  logic [3:0]  out_cry;
  logic        ret_vld;
  logic [7:0]  ret_ofs;

  per_period_offset_pipe dut (
    .clk(clk), .rst(rst), .t0_en(t0_en), .ofs_in(ofs_in), .dly_in(dly_in),
    .align_sel(align_sel), .out_vld(out_vld), .out_dly(out_dly),
    .out_cry(out_cry), .ret_vld(ret_vld), .ret_ofs(ret_ofs)
  );

  always #2.5 clk = ~clk;

  typedef struct packed { logic [31:0] d; logic [3:0] c; } exp_t;
  exp_t        exp_q [$];
  int          sedge [$];
  logic [7:0]  shist [$];
  int          ecnt = 0;
  int          total = 0;
  int          bad = 0;
  int          nout = 0;

  always @(posedge clk) ecnt++;

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic junk();
    t0_en  = 1'b0;
    ofs_in = 8'($urandom);
    dly_in = $urandom;
  endtask

  task automatic do_strobe(input logic [7:0] o, input logic [31:0] d, input int gap);
    exp_t e;
    int k;
    int idx;
    t0_en  = 1'b1;
    ofs_in = o;
    dly_in = d;
    for (int c = 0; c < 4; c++) begin
      logic [8:0] s;
      s = {1'b0, d[c*8 +: 8]} + {1'b0, o};
      e.d[c*8 +: 8] = s[7:0];
      e.c[c]        = s[8];
    end
    exp_q.push_back(e);
    sedge.push_back(ecnt + 1);
    shist.push_back(o);
    @(negedge clk);
    k   = sedge.size() - 1;
    idx = k - 7 - int'(align_sel);
    if (idx >= 0) begin
      chk(ret_vld == 1'b1, "R8 ret_vld high", 40'(ret_vld), 40'(1));
      chk(ret_ofs == shist[idx], "R7 ret_ofs", 40'(ret_ofs), 40'(shist[idx]));
    end else begin
      chk(ret_vld == 1'b0, "R8 ret_vld low", 40'(ret_vld), 40'(0));
    end
    if (gap > 0) begin
      junk();
      repeat (gap - 1) begin
        @(negedge clk);
        junk();
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      junk();
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic [2:0] a);
    rst = 1'b1;
    t0_en = 1'b0;
    align_sel = a;
    repeat (3) @(negedge clk);
    exp_q.delete();
    sedge.delete();
    shist.delete();
    nout = 0;
    rst = 1'b0;
    chk(out_vld == 1'b0 && ret_vld == 1'b0, "R1 valids cleared", 40'({out_vld, ret_vld}), 40'(0));
    chk(out_dly == '0 && out_cry == '0, "R1 data cleared", {out_cry, out_dly}, 40'(0));
  endtask

  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected out_vld", 40'(1), 40'(0));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(out_dly == e.d, "R3 R4 R9 out_dly", 40'(out_dly), 40'(e.d));
        chk(out_cry == e.c, "R3 out_cry", 40'(out_cry), 40'(e.c));
        if (sedge.size() > nout + 3)
          chk(ecnt == sedge[nout+3] + 4, "R5 latency", 40'(ecnt), 40'(sedge[nout+3] + 4));
        else
          chk(1'b0, "R5 early output", 40'(ecnt), 40'(0));
        nout++;
      end
    end
  end

  task automatic end_phase();
    idle(12);
    chk(exp_q.size() == 3, "R6 items = strobes - 3", 40'(exp_q.size()), 40'(3));
  endtask

  initial begin
    @(negedge clk);
    do_reset(3'd0);
    do_strobe(8'h00, 32'h00000000, 6);
    do_strobe(8'h01, 32'hFF000000, 6);
    do_strobe(8'hFF, 32'hFF01FE00, 6);
    do_strobe(8'h80, 32'h7F80817F, 6);
    for (int i = 0; i < 10; i++) do_strobe(8'($urandom), $urandom, 3 + (i % 4));
    end_phase();

    for (int i = 0; i < 14; i++) do_strobe(8'($urandom), $urandom, 0);
    end_phase();

    do_reset(3'd5);
    for (int i = 0; i < 20; i++) do_strobe(8'($urandom), $urandom, i % 3);
    end_phase();

    do_reset(3'd7);
    for (int i = 0; i < 24; i++) do_strobe(8'(i * 11), 32'h01234567 ^ 32'(i), 2);
    end_phase();

    do_reset(3'd2);
    for (int i = 0; i < 12; i++) do_strobe(8'hFF - 8'(i), 32'hFFFFFFFF, 1);
    end_phase();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule